// File: doc/BRIEF.md
# Retention Register Bank

This block models a small bank of state registers that live in a switchable power domain. Each register has a second, always-powered copy. Before the domain is switched off, a controller pulses a capture request. The current contents are then moved into the always-powered copies over a fixed number of clock cycles. After power returns, a single recovery request loads every main register back from its copy, in one cycle.

While the domain supply is off, the main registers hold a fixed corruption pattern and refuse writes. The outputs that leave the domain pass through per-register isolation clamps. When isolation is on, each output is forced to all zeros or all ones, or it freezes at the value it showed when isolation began. The choice is fixed per register by a parameter.

The bank also watches the order of the power-sequence controls. It raises a one-cycle `seq_err` pulse when it sees any of these:
- the supply is lost while a capture is still in flight;
- a recovery is requested with the supply off;
- a functional write arrives after a wake but before recovery;
- capture and recovery are requested together.

Top module: `retention_bank`

## Requirements
- R1: With `rst` high at a clock edge, all main registers, the always-powered copies and the held clamp values become 0. `dout` reads 0, and `save_busy` and `seq_err` are 0.
- R2: When `wr_en` is high, the supply is on and no recovery is outstanding, the register selected by `wr_addr` takes `wr_data` at the clock edge. Register i occupies `dout[i*W +: W]`.
- R3: A `save` pulse (with `restore` low and the supply on) samples every main register at that edge. `save_busy` is then high for exactly SAVE_LAT cycles. The sampled values enter the always-powered copies at the edge where `save_busy` falls. Writes made after the save edge do not reach the copies.
- R4: A `restore` pulse (with `save` low and the supply on) loads every main register from its always-powered copy at that edge. A write in the same cycle is dropped without error.
- R5: At every edge with `pwr_on` low, each main register becomes CORRUPT_PAT (default 8'hA5) and writes are ignored. The always-powered copies keep their contents.
- R6: With `iso_en` high, register i's output follows a 2-bit code at `CLAMP_MODES[2*i +: 2]`. Code 0 gives all zeros and code 1 gives all ones. Code 2 holds the value the output showed in the last cycle before isolation. Code 3 acts as code 0. The default codes are 2, 0, 1, 2 for registers 0 to 3.
- R7: An edge with `pwr_on` low while `save_busy` is high aborts the capture. `save_busy` drops and `seq_err` is raised. The copies keep their older contents.
- R8: A `restore` with `pwr_on` low raises `seq_err` and changes nothing.
- R9: Any edge with `pwr_on` low arms a recovery-pending state. While it is armed, a write with the supply on raises `seq_err` and is dropped. A successful restore clears the state and writes work again.
- R10: `save` and `restore` high together raise `seq_err`. Neither the capture nor the reload takes place.
- R11: `seq_err` is high in the cycle after an edge that saw a violation and low after an edge that saw none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Domain supply present |
| iso_en | input | 1 | Output isolation enable |
| wr_en | input | 1 | Functional write strobe |
| wr_addr | input | AW | Register index for the write |
| wr_data | input | W | Write data |
| save | input | 1 | Capture request into always-powered copies |
| restore | input | 1 | Reload request from always-powered copies |
| dout | output | NREG*W | Isolated register outputs, register i at bits i*W upward |
| save_busy | output | 1 | Capture in flight |
| seq_err | output | 1 | Sequence violation seen at the previous edge |

## Verification
The assertions assume that `rst` is high at the first clock edge and that `iso_en` is low during reset. Without this, the first-edge history of the hold clamps would be undefined. They also assume that `wr_addr` always names a register that exists. The stimulus changes every input on the falling clock edge and holds it through the next rising edge, and it only ever addresses registers 0 to 3. The stimulus also raises `iso_en` while the supply is on and the outputs are stable, so each frozen value is a known register state. Power is dropped both with and without a capture in flight, so that the abort rule is exercised separately from a clean shutdown.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    // Output clamp behaviour selected per register while isolated.
    typedef enum logic [1:0] {
        CLAMP_ZERO = 2'd0,
        CLAMP_ONE  = 2'd1,
        CLAMP_HOLD = 2'd2,
        CLAMP_RSVD = 2'd3
    } clamp_e;

    // Per-cycle actions the sequence controller grants to every cell.
    typedef struct packed {
        logic capture;  // sample main into staging
        logic commit;   // staging into always-powered copy
        logic restore;  // copy back into main
        logic write;    // functional write allowed this cycle
    } bank_cmd_t;

    function automatic clamp_e clamp_code(input logic [1:0] code);
        return (code == 2'd3) ? CLAMP_ZERO : clamp_e'(code);
    endfunction

    function automatic int unsigned cnt_width(input int unsigned lat);
        return (lat < 2) ? 1 : $clog2(lat + 1);
    endfunction

endpackage

// File: rtl/rrb_seq_ctrl.sv
module rrb_seq_ctrl
    import rrb_pkg::*;
#(
    parameter int unsigned SAVE_LAT = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_on,
    input  logic      wr_en,
    input  logic      save,
    input  logic      restore,
    output bank_cmd_t cmd,
    output logic      save_busy,
    output logic      seq_err
);

    localparam int unsigned CW = cnt_width(SAVE_LAT);

    logic [CW-1:0] cnt_q;
    logic          need_rst_q;
    logic          busy;
    logic          save_ok;
    logic          restore_ok;
    logic          viol;

    always_comb begin
        busy        = (cnt_q != '0);
        save_ok     = save & ~restore & pwr_on;
        restore_ok  = restore & ~save & pwr_on;
        cmd.capture = save_ok;
        cmd.commit  = pwr_on & (cnt_q == CW'(1));
        cmd.restore = restore_ok;
        cmd.write   = wr_en & pwr_on & ~need_rst_q & ~restore_ok;
        viol        = (save & restore)
                    | (restore & ~save & ~pwr_on)
                    | (~pwr_on & busy)
                    | (wr_en & pwr_on & need_rst_q & ~restore_ok);
    end

    assign save_busy = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            need_rst_q <= 1'b0;
            seq_err    <= 1'b0;
        end else begin
            seq_err <= viol;
            if (!pwr_on)
                cnt_q <= '0;
            else if (save_ok)
                cnt_q <= CW'(SAVE_LAT);
            else if (busy)
                cnt_q <= cnt_q - CW'(1);
            if (!pwr_on)
                need_rst_q <= 1'b1;
            else if (restore_ok)
                need_rst_q <= 1'b0;
        end
    end

    p_save_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (save && !restore && pwr_on) |=> save_busy);

    p_abort_r7: assert property (@(posedge clk) disable iff (rst)
        (!pwr_on && save_busy) |=> (!save_busy && seq_err));

    p_restore_off_r8: assert property (@(posedge clk) disable iff (rst)
        (restore && !save && !pwr_on) |=> seq_err);

    p_both_err_r10: assert property (@(posedge clk) disable iff (rst)
        (save && restore) |=> seq_err);

    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!save && !restore && !wr_en && pwr_on && !save_busy) |=> !seq_err);

endmodule

// File: rtl/rrb_cell.sv
module rrb_cell
    import rrb_pkg::*;
#(
    parameter int unsigned W          = 8,
    parameter int unsigned AW         = 2,
    parameter int unsigned IDX        = 0,
    parameter logic [W-1:0] CORRUPT   = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_on,
    input  bank_cmd_t     cmd,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  main_q,
    output logic [W-1:0]  main_nx
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] stage_q;
    logic         hit;

    assign hit = (wr_addr == AW'(IDX));

    always_comb begin
        main_nx = main_q;
        if (!pwr_on)
            main_nx = CORRUPT;
        else if (cmd.restore)
            main_nx = shadow_q;
        else if (cmd.write && hit)
            main_nx = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q   <= '0;
            shadow_q <= '0;
            stage_q  <= '0;
        end else begin
            main_q <= main_nx;
            if (cmd.capture)
                stage_q <= main_q;
            if (cmd.commit)
                shadow_q <= stage_q;
        end
    end

    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        (pwr_on && cmd.write && hit && !cmd.restore) |=> (main_q == $past(wr_data)));

    p_restore_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.restore |=> (main_q == $past(shadow_q)));

    p_off_corrupt_r5: assert property (@(posedge clk) disable iff (rst)
        !pwr_on |=> (main_q == CORRUPT));

    p_shadow_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !cmd.commit |=> $stable(shadow_q));

endmodule

// File: rtl/rrb_iso.sv
module rrb_iso
    import rrb_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter logic [1:0]  MODE = 2'd0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         iso_en,
    input  logic [W-1:0] main_q,
    input  logic [W-1:0] main_nx,
    output logic [W-1:0] dout
);

    localparam clamp_e MODE_E = clamp_code(MODE);

    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (!iso_en)
            hold_q <= main_nx;
    end

    always_comb begin
        if (!iso_en) begin
            dout = main_q;
        end else begin
            case (MODE_E)
                CLAMP_ONE:  dout = '1;
                CLAMP_HOLD: dout = hold_q;
                default:    dout = '0;
            endcase
        end
    end

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (MODE_E == CLAMP_HOLD && iso_en && $past(iso_en)) |-> $stable(dout));

    p_hold_entry_r6: assert property (@(posedge clk) disable iff (rst)
        (MODE_E == CLAMP_HOLD && $rose(iso_en)) |-> (dout == $past(main_nx)));

endmodule

// File: rtl/retention_bank.sv
module retention_bank
    import rrb_pkg::*;
#(
    parameter int unsigned   NREG        = 4,
    parameter int unsigned   W           = 8,
    parameter int unsigned   SAVE_LAT    = 2,
    parameter logic [W-1:0]  CORRUPT_PAT = 8'hA5,
    parameter logic [2*NREG-1:0] CLAMP_MODES = 8'b10_01_00_10,
    localparam int unsigned  AW          = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_on,
    input  logic              iso_en,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              save,
    input  logic              restore,
    output logic [NREG*W-1:0] dout,
    output logic              save_busy,
    output logic              seq_err
);

    bank_cmd_t cmd;

    rrb_seq_ctrl #(
        .SAVE_LAT (SAVE_LAT)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pwr_on    (pwr_on),
        .wr_en     (wr_en),
        .save      (save),
        .restore   (restore),
        .cmd       (cmd),
        .save_busy (save_busy),
        .seq_err   (seq_err)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [W-1:0] main_q;
        logic [W-1:0] main_nx;

        rrb_cell #(
            .W       (W),
            .AW      (AW),
            .IDX     (i),
            .CORRUPT (CORRUPT_PAT)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .pwr_on  (pwr_on),
            .cmd     (cmd),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .main_q  (main_q),
            .main_nx (main_nx)
        );

        rrb_iso #(
            .W    (W),
            .MODE (CLAMP_MODES[2*i +: 2])
        ) u_iso (
            .clk     (clk),
            .rst     (rst),
            .iso_en  (iso_en),
            .main_q  (main_q),
            .main_nx (main_nx),
            .dout    (dout[i*W +: W])
        );
    end

endmodule

// File: tb/retention_bank_tb_top.sv
module retention_bank_tb_top;

    localparam int N  = 4;
    localparam int W  = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_on = 1'b1;
    logic          iso_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          save = 1'b0;
    logic          restore = 1'b0;
    logic [N*W-1:0] dout;
    logic          save_busy;
    logic          seq_err;

    always #2 clk = ~clk;

    retention_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .pwr_on    (pwr_on),
        .iso_en    (iso_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .save      (save),
        .restore   (restore),
        .dout      (dout),
        .save_busy (save_busy),
        .seq_err   (seq_err)
    );

    typedef struct {
        string         req;
        logic [31:0]   dv;
        bit            err;
        bit            busy;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    function automatic logic [31:0] pk(input logic [7:0] r3, input logic [7:0] r2,
                                       input logic [7:0] r1, input logic [7:0] r0);
        return {r3, r2, r1, r0};
    endfunction

    // Driver: apply one cycle of stimulus on the falling edge.
    task automatic drive(input bit we, input int a, input logic [7:0] d,
                         input bit sv, input bit rs, input bit pw, input bit iso);
        @(negedge clk);
        wr_en   = we;
        wr_addr = AW'(a);
        wr_data = d;
        save    = sv;
        restore = rs;
        pwr_on  = pw;
        iso_en  = iso;
    endtask

    // Expectation for the outputs after the coming rising edge.
    task automatic expect_out(input string req, input logic [31:0] dv,
                              input bit err, input bit busy);
        exp_t it;
        it.req  = req;
        it.dv   = dv;
        it.err  = err;
        it.busy = busy;
        sb_q.push_back(it);
    endtask

    task automatic idle(input bit pw, input bit iso);
        drive(0, 0, 8'h00, 0, 0, pw, iso);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (dout !== it.dv || seq_err !== it.err || save_busy !== it.busy) begin
                    failures++;
                    $display("FAIL %s dout=%h exp=%h seq_err=%b exp=%b save_busy=%b exp=%b",
                             it.req, dout, it.dv, seq_err, it.err, save_busy, it.busy);
                end
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out("R1 reset state", 32'h0, 0, 0);

        drive(1, 0, 8'h11, 0, 0, 1, 0); expect_out("R2 write r0", pk(8'h00, 8'h00, 8'h00, 8'h11), 0, 0);
        drive(1, 1, 8'h22, 0, 0, 1, 0); expect_out("R2 write r1", pk(8'h00, 8'h00, 8'h22, 8'h11), 0, 0);
        drive(1, 2, 8'h33, 0, 0, 1, 0); expect_out("R2 write r2", pk(8'h00, 8'h33, 8'h22, 8'h11), 0, 0);
        drive(1, 3, 8'h44, 0, 0, 1, 0); expect_out("R2 write r3", pk(8'h44, 8'h33, 8'h22, 8'h11), 0, 0);

        drive(0, 0, 8'h00, 1, 0, 1, 0); expect_out("R3 save busy 1", pk(8'h44, 8'h33, 8'h22, 8'h11), 0, 1);
        idle(1, 0);                     expect_out("R3 save busy 2", pk(8'h44, 8'h33, 8'h22, 8'h11), 0, 1);
        idle(1, 0);                     expect_out("R3 save done", pk(8'h44, 8'h33, 8'h22, 8'h11), 0, 0);

        drive(1, 0, 8'h55, 0, 0, 1, 0); expect_out("R2 overwrite r0", pk(8'h44, 8'h33, 8'h22, 8'h55), 0, 0);
        idle(1, 1);                     expect_out("R6 clamp codes", pk(8'h44, 8'hFF, 8'h00, 8'h55), 0, 0);
        drive(1, 3, 8'h77, 0, 0, 1, 1); expect_out("R6 hold frozen", pk(8'h44, 8'hFF, 8'h00, 8'h55), 0, 0);
        idle(0, 1);                     expect_out("R6 clamp at power off", pk(8'h44, 8'hFF, 8'h00, 8'h55), 0, 0);
        drive(1, 1, 8'h99, 0, 0, 0, 0); expect_out("R5 corrupt pattern", pk(8'hA5, 8'hA5, 8'hA5, 8'hA5), 0, 0);
        drive(0, 0, 8'h00, 0, 1, 0, 0); expect_out("R8 restore while off", pk(8'hA5, 8'hA5, 8'hA5, 8'hA5), 1, 0);
        idle(0, 0);                     expect_out("R11 flag clears", pk(8'hA5, 8'hA5, 8'hA5, 8'hA5), 0, 0);
        idle(1, 1);                     expect_out("R6 clamp on wake", pk(8'hA5, 8'hFF, 8'h00, 8'hA5), 0, 0);
        drive(1, 2, 8'h12, 0, 0, 1, 1); expect_out("R9 write before restore", pk(8'hA5, 8'hFF, 8'h00, 8'hA5), 1, 0);
        drive(0, 0, 8'h00, 0, 1, 1, 1); expect_out("R4 restore under isolation", pk(8'hA5, 8'hFF, 8'h00, 8'hA5), 0, 0);
        idle(1, 0);                     expect_out("R4 restored values", pk(8'h44, 8'h33, 8'h22, 8'h11), 0, 0);
        drive(1, 2, 8'h12, 0, 0, 1, 0); expect_out("R9 write after restore", pk(8'h44, 8'h12, 8'h22, 8'h11), 0, 0);

        drive(1, 0, 8'h66, 0, 0, 1, 0); expect_out("R2 write r0 again", pk(8'h44, 8'h12, 8'h22, 8'h66), 0, 0);
        drive(0, 0, 8'h00, 1, 1, 1, 0); expect_out("R10 save with restore", pk(8'h44, 8'h12, 8'h22, 8'h66), 1, 0);
        drive(0, 0, 8'h00, 0, 1, 1, 0); expect_out("R10 copies untouched", pk(8'h44, 8'h33, 8'h22, 8'h11), 0, 0);

        drive(1, 0, 8'h66, 0, 0, 1, 0); expect_out("R2 write before abort", pk(8'h44, 8'h33, 8'h22, 8'h66), 0, 0);
        drive(0, 0, 8'h00, 1, 0, 1, 0); expect_out("R7 save started", pk(8'h44, 8'h33, 8'h22, 8'h66), 0, 1);
        idle(0, 0);                     expect_out("R7 power lost mid save", pk(8'hA5, 8'hA5, 8'hA5, 8'hA5), 1, 0);
        idle(1, 0);                     expect_out("R11 quiet after wake", pk(8'hA5, 8'hA5, 8'hA5, 8'hA5), 0, 0);
        drive(0, 0, 8'h00, 0, 1, 1, 0); expect_out("R7 aborted save left copies", pk(8'h44, 8'h33, 8'h22, 8'h11), 0, 0);

        drive(1, 1, 8'hBB, 0, 0, 1, 0); expect_out("R2 write r1", pk(8'h44, 8'h33, 8'hBB, 8'h11), 0, 0);
        drive(0, 0, 8'h00, 1, 0, 1, 0); expect_out("R3 second save", pk(8'h44, 8'h33, 8'hBB, 8'h11), 0, 1);
        idle(1, 0);                     expect_out("R3 second save busy", pk(8'h44, 8'h33, 8'hBB, 8'h11), 0, 1);
        idle(1, 0);                     expect_out("R3 second save done", pk(8'h44, 8'h33, 8'hBB, 8'h11), 0, 0);
        drive(1, 1, 8'hCC, 0, 0, 1, 0); expect_out("R2 write after save", pk(8'h44, 8'h33, 8'hCC, 8'h11), 0, 0);
        drive(0, 0, 8'h00, 0, 1, 1, 0); expect_out("R3 captured value returns", pk(8'h44, 8'h33, 8'hBB, 8'h11), 0, 0);

        idle(1, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule